// File: doc/BRIEF.md
# SMI Status Aggregator

This block gathers system-management interrupt events into one 16-bit top-level status word and drives a single SMI request line. Most top-level bits are sticky flags. Each one is set by a direct event whose own enable bit is 1, and a read of the primary status address clears them. Two top-level bits work differently. They are read-only summaries of second-level registers, one for power-management events and one for audio events. Software clears those second-level registers by writing ones to them.

The power-management group has a further level below it. Its bit 0 summarises a third-level register of general-purpose input events. Clearing the third-level bits therefore clears the second-level bit and the top-level summary in turn. Software that only wants to look at the status uses a mirror address. It returns the same word and clears nothing, so the SMI line stays asserted.

The register port works in single cycles. It has a read strobe, a write strobe, an address and write data. The read data is registered and holds its value between reads.

Top module: `smi_status_hub`

## Requirements
- R1: After reset, every status and enable register is 0, rd_data_o is 0 and smi_o is 0.
- R2: A direct event input on top-level bit 2, 3 or 5..14 sets that bit only when the matching bit of the top enable register (address 2) is 1. Bit 6 is the timer-expiry source and bit 5 is the video-retrace source. The bit stays 1 until it is cleared.
- R3: A read of address 0 returns the top-level word as it was before the access, on rd_data_o one cycle after the strobe. In the same access it clears every sticky top-level bit: bits 2, 3 and 5..15.
- R4: If a sticky top-level bit has a set condition in the same cycle as a clearing read of address 0, the bit is 1 after that cycle.
- R5: A read of address 1 returns the same word as address 0 and leaves every status bit unchanged.
- R6: Top-level bit 4 always reads 0. Only bits 2, 3 and 5..14 of the top enable register can be written; the other bits read 0.
- R7: Top-level bit 15 is set in every cycle where the suspend-configuration input is 1. A read of address 0 clears it.
- R8: A second-level bit (power management at address 3, audio at address 5, general-purpose inputs at address 7) is set by its event input whether or not its enable bit is 1. Writing 1 to the bit clears it. An event in the same cycle as such a write leaves the bit at 1.
- R9: Top-level bit 0 is the OR of (power-management status AND enable at address 4). Top-level bit 1 is the OR of (audio status AND enable at address 6). A read of address 0 does not clear either bit.
- R10: Power-management bit 0 is the OR of (general-purpose status AND enable at address 8). Writes and events on that bit are ignored. It clears only when the general-purpose bits clear.
- R11: In each cycle, smi_o equals the OR of the top-level word from the cycle before.
- R12: Addresses 2, 4, 6 and 8 read back the enable registers as written. Addresses 9..15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read strobe, one cycle |
| wr_en_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| evt_i | input | 16 | Direct top-level events; bits 2, 3 and 5..14 are used |
| pm_evt_i | input | N_PM | Power-management event inputs |
| aud_evt_i | input | N_AUD | Audio event inputs |
| gpio_evt_i | input | N_GPIO | General-purpose input events |
| susp_cfg_i | input | 1 | Suspend-mode configuration level |
| smi_o | output | 1 | SMI request |

## Verification
The assertions assume that reset is held from time zero. The clear and mirror properties also assume that no write strobe is active in the same cycle as the read they look at. The bench never raises both strobes in one cycle. The read-clear property only checks cycles in which no direct event and no suspend level are present. The bench mixes sparse random events, which are often absent, with directed cycles that keep these inputs quiet while a clear is being checked.

// File: rtl/smi_hub_pkg.sv
package smi_hub_pkg;
  localparam int STAT_W = 16;
  localparam int ADDR_W = 4;
  // top-level bits fed by direct, enable-gated events
  localparam logic [STAT_W-1:0] EVT_MASK = 16'h7FEC;
  // top-level bits cleared by a primary read
  localparam logic [STAT_W-1:0] RC_MASK  = 16'hFFEC;
  localparam int SUM_PM_BIT  = 0;
  localparam int SUM_AUD_BIT = 1;
  localparam int SUSP_BIT    = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_TOP     = 4'd0,
    A_MIRROR  = 4'd1,
    A_TOPEN   = 4'd2,
    A_PMSTAT  = 4'd3,
    A_PMEN    = 4'd4,
    A_AUDSTAT = 4'd5,
    A_AUDEN   = 4'd6,
    A_GPSTAT  = 4'd7,
    A_GPEN    = 4'd8
  } hub_addr_e;
endpackage

// File: rtl/smi_w1c_bank.sv
module smi_w1c_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] RO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ro_i,
  input  logic         stat_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         sum_o
);
  logic [W-1:0] en_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RO_MASK[i]) begin : g_ro
      // summary of a lower level: follows it, ignores writes and events
      logic unused_set;
      assign unused_set = set_i[i];
      assign stat_o[i]  = ro_i[i];
    end else begin : g_sticky
      logic bit_q;
      logic unused_ro;
      assign unused_ro = ro_i[i];
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= (bit_q & ~(stat_we_i & wdata_i[i])) | set_i[i];
      end
      assign stat_o[i] = bit_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  assign en_o  = en_q;
  assign sum_o = |(stat_o & en_q);
endmodule

// File: rtl/smi_rc_status.sv
module smi_rc_status #(
  parameter int W = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // a set in the clearing cycle wins
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= ((clr_i ? '0 : stat_q) | set_i) & KEEP;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/smi_status_hub.sv
module smi_status_hub
  import smi_hub_pkg::*;
#(
  parameter int N_PM   = 8,
  parameter int N_AUD  = 8,
  parameter int N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rd_data_o,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [N_PM-1:0]   pm_evt_i,
  input  logic [N_AUD-1:0]  aud_evt_i,
  input  logic [N_GPIO-1:0] gpio_evt_i,
  input  logic              susp_cfg_i,
  output logic              smi_o
);
  localparam logic [N_PM-1:0] PM_RO = N_PM'(1);

  logic [STAT_W-1:0] top_en_q, rc_set, rc_stat, top_view, rd_mux, rd_q;
  logic [N_PM-1:0]   pm_stat, pm_en;
  logic [N_AUD-1:0]  aud_stat, aud_en;
  logic [N_GPIO-1:0] gp_stat, gp_en;
  logic              pm_sum, aud_sum, gp_sum, smi_q;
  logic              unused_hub;

  assign unused_hub = ^(evt_i & ~EVT_MASK);

  function automatic logic wr_at(input hub_addr_e a);
    return wr_en_i && (addr_i == a);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)             top_en_q <= '0;
    else if (wr_at(A_TOPEN)) top_en_q <= wdata_i & EVT_MASK;
  end

  smi_w1c_bank #(.W(N_GPIO), .RO_MASK('0)) u_gp_bank (
    .clk(clk), .rst(rst), .set_i(gpio_evt_i), .ro_i('0),
    .stat_we_i(wr_at(A_GPSTAT)), .en_we_i(wr_at(A_GPEN)),
    .wdata_i(wdata_i[N_GPIO-1:0]),
    .stat_o(gp_stat), .en_o(gp_en), .sum_o(gp_sum));

  smi_w1c_bank #(.W(N_PM), .RO_MASK(PM_RO)) u_pm_bank (
    .clk(clk), .rst(rst), .set_i(pm_evt_i), .ro_i(N_PM'(gp_sum)),
    .stat_we_i(wr_at(A_PMSTAT)), .en_we_i(wr_at(A_PMEN)),
    .wdata_i(wdata_i[N_PM-1:0]),
    .stat_o(pm_stat), .en_o(pm_en), .sum_o(pm_sum));

  smi_w1c_bank #(.W(N_AUD), .RO_MASK('0)) u_aud_bank (
    .clk(clk), .rst(rst), .set_i(aud_evt_i), .ro_i('0),
    .stat_we_i(wr_at(A_AUDSTAT)), .en_we_i(wr_at(A_AUDEN)),
    .wdata_i(wdata_i[N_AUD-1:0]),
    .stat_o(aud_stat), .en_o(aud_en), .sum_o(aud_sum));

  always_comb begin
    rc_set = evt_i & top_en_q & EVT_MASK;
    rc_set[SUSP_BIT] = susp_cfg_i;
  end

  smi_rc_status #(.W(STAT_W), .KEEP(RC_MASK)) u_rc (
    .clk(clk), .rst(rst), .set_i(rc_set),
    .clr_i(rd_en_i && (addr_i == A_TOP)),
    .stat_o(rc_stat));

  always_comb begin
    top_view = rc_stat;
    top_view[SUM_PM_BIT]  = pm_sum;
    top_view[SUM_AUD_BIT] = aud_sum;
  end

  always_comb begin
    case (addr_i)
      A_TOP, A_MIRROR: rd_mux = top_view;
      A_TOPEN:         rd_mux = top_en_q;
      A_PMSTAT:        rd_mux = STAT_W'(pm_stat);
      A_PMEN:          rd_mux = STAT_W'(pm_en);
      A_AUDSTAT:       rd_mux = STAT_W'(aud_stat);
      A_AUDEN:         rd_mux = STAT_W'(aud_en);
      A_GPSTAT:        rd_mux = STAT_W'(gp_stat);
      A_GPEN:          rd_mux = STAT_W'(gp_en);
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      smi_q <= 1'b0;
    end else begin
      if (rd_en_i) rd_q <= rd_mux;
      smi_q <= |top_view;
    end
  end

  assign rd_data_o = rd_q;
  assign smi_o     = smi_q;
endmodule

// File: rtl/smi_status_hub_chk.sv
module smi_status_hub_chk
  import smi_hub_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [STAT_W-1:0] evt_i,
  input logic              susp_cfg_i,
  input logic [STAT_W-1:0] rd_data_o,
  input logic              smi_o,
  input logic [STAT_W-1:0] top_view
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0 && !smi_o));

  // R3
  a_r3_read_returns_old: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_TOP) |=> (rd_data_o == $past(top_view)));

  // R3
  a_r3_sticky_cleared: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i && addr_i == A_TOP && evt_i == '0 && !susp_cfg_i)
      |=> ((top_view & RC_MASK) == '0));

  // R4
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_TOP && susp_cfg_i) |=> top_view[SUSP_BIT]);

  // R5
  a_r5_mirror_keeps: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i && addr_i == A_MIRROR)
      |=> ((top_view & $past(top_view)) == $past(top_view)));

  // R6
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !top_view[4]);

  // R9
  a_r9_summary_survives: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i && addr_i == A_TOP)
      |=> ((top_view[1:0] & $past(top_view[1:0])) == $past(top_view[1:0])));

  // R11
  a_r11_smi_follows: assert property (@(posedge clk) disable iff (rst)
    smi_o == $past(|top_view));
endmodule

bind smi_status_hub smi_status_hub_chk u_chk (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .evt_i(evt_i), .susp_cfg_i(susp_cfg_i),
  .rd_data_o(rd_data_o), .smi_o(smi_o), .top_view(top_view));

// File: tb/smi_status_hub_bench.sv
`timescale 1ns/1ps
module smi_status_hub_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0, susp = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, evt = '0;
  logic [7:0]  pm_ev = '0, aud_ev = '0, gp_ev = '0;
  logic [15:0] rd_data;
  logic        smi;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_top = '0, m_topen = '0, m_rd = '0;
  logic [7:0]  m_pm = '0, m_pmen = '0, m_aud = '0, m_auden = '0, m_gp = '0, m_gpen = '0;
  logic        m_smi = 1'b0;

  localparam logic [15:0] EVT_M = 16'h7FEC;

  always #2.5 clk = ~clk;

  smi_status_hub u_smi_status_hub (
    .clk(clk), .rst(rst), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_data_o(rd_data), .evt_i(evt), .pm_evt_i(pm_ev),
    .aud_evt_i(aud_ev), .gpio_evt_i(gp_ev), .susp_cfg_i(susp), .smi_o(smi));

  function automatic logic [7:0] f_pm_view();
    return (m_pm & 8'hFE) | {7'b0, |(m_gp & m_gpen)};
  endfunction

  function automatic logic [15:0] f_top_view();
    logic [15:0] v;
    v = m_top;
    v[0] = |(f_pm_view() & m_pmen);
    v[1] = |(m_aud & m_auden);
    return v;
  endfunction

  function automatic logic [15:0] f_read(input logic [3:0] a);
    case (a)
      4'd0, 4'd1: return f_top_view();
      4'd2: return m_topen;
      4'd3: return {8'b0, f_pm_view()};
      4'd4: return {8'b0, m_pmen};
      4'd5: return {8'b0, m_aud};
      4'd6: return {8'b0, m_auden};
      4'd7: return {8'b0, m_gp};
      4'd8: return {8'b0, m_gpen};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model next state, edge, compare, clear pulses
  task automatic step();
    logic [15:0] n_top, n_topen, n_rd;
    logic [7:0]  n_pm, n_pmen, n_aud, n_auden, n_gp, n_gpen;
    logic        n_smi;
    n_rd = rd_en ? f_read(addr) : m_rd;
    n_smi = |f_top_view();
    n_top = ((rd_en && addr == 4'd0) ? 16'h0 : m_top) | (evt & m_topen & EVT_M) | {susp, 15'b0};
    n_topen = (wr_en && addr == 4'd2) ? (wdata & EVT_M) : m_topen;
    n_pm = ((m_pm & ~((wr_en && addr == 4'd3) ? wdata[7:0] : 8'h0)) | pm_ev) & 8'hFE;
    n_aud = (m_aud & ~((wr_en && addr == 4'd5) ? wdata[7:0] : 8'h0)) | aud_ev;
    n_gp = (m_gp & ~((wr_en && addr == 4'd7) ? wdata[7:0] : 8'h0)) | gp_ev;
    n_pmen = (wr_en && addr == 4'd4) ? wdata[7:0] : m_pmen;
    n_auden = (wr_en && addr == 4'd6) ? wdata[7:0] : m_auden;
    n_gpen = (wr_en && addr == 4'd8) ? wdata[7:0] : m_gpen;
    @(posedge clk);
    #1;
    m_top = n_top; m_topen = n_topen; m_rd = n_rd; m_smi = n_smi;
    m_pm = n_pm; m_aud = n_aud; m_gp = n_gp;
    m_pmen = n_pmen; m_auden = n_auden; m_gpen = n_gpen;
    check("R3 R11 model rd_data", rd_data, m_rd);
    check("R11 model smi", {15'b0, smi}, {15'b0, m_smi});
    rd_en = 0; wr_en = 0; evt = '0; pm_ev = '0; aud_ev = '0; gp_ev = '0; susp = 0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [15:0] v);
    rd_en = 1; addr = a; step(); v = rd_data;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d; step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1
    check("R1 rd_data after reset", rd_data, 16'h0);
    check("R1 smi after reset", {15'b0, smi}, 16'h0);
    do_rd(4'd1, v); check("R1 top word zero", v, 16'h0);
    // R6 R12
    do_wr(4'd2, 16'hFFFF);
    do_rd(4'd2, v); check("R6 R12 enable writable bits", v, 16'h7FEC);
    // R2: timer enabled, retrace not
    do_wr(4'd2, 16'h0040);
    evt = 16'h0060; step();
    do_rd(4'd1, v); check("R2 only enabled timer sets", v, 16'h0040);
    check("R11 smi raised", {15'b0, smi}, 16'h1);
    do_rd(4'd1, v); check("R5 mirror keeps status", v, 16'h0040);
    do_rd(4'd0, v); check("R3 primary read old value", v, 16'h0040);
    do_rd(4'd1, v); check("R3 cleared after read", v, 16'h0);
    check("R11 smi dropped", {15'b0, smi}, 16'h0);
    // R4
    do_wr(4'd2, 16'h0020);
    evt = 16'h0020; do_rd(4'd0, v); check("R4 read value before set", v, 16'h0);
    do_rd(4'd1, v); check("R4 set wins over clear", v, 16'h0020);
    do_rd(4'd0, v);
    // R6
    do_wr(4'd2, 16'hFFFF);
    evt = 16'hFFFF; step();
    do_rd(4'd1, v); check("R6 bit4 and summaries stay 0", v, 16'h7FEC);
    do_rd(4'd0, v);
    do_wr(4'd2, 16'h0000);
    // R7
    susp = 1; step();
    do_rd(4'd1, v); check("R7 suspend bit set", v, 16'h8000);
    do_rd(4'd0, v); check("R7 read returns suspend", v, 16'h8000);
    do_rd(4'd1, v); check("R7 suspend bit cleared", v, 16'h0);
    // R8 R9
    pm_ev = 8'h08; step();
    do_rd(4'd3, v); check("R8 sets without enable", v, 16'h0008);
    do_rd(4'd1, v); check("R9 gated by enable", v, 16'h0);
    do_wr(4'd4, 16'h0008);
    do_rd(4'd1, v); check("R9 pm summary", v, 16'h0001);
    do_rd(4'd0, v);
    do_rd(4'd1, v); check("R9 summary not cleared by read", v, 16'h0001);
    do_wr(4'd3, 16'h0008);
    do_rd(4'd1, v); check("R8 w1c clears summary", v, 16'h0);
    pm_ev = 8'h04; do_wr(4'd3, 16'h0004);
    do_rd(4'd3, v); check("R8 event wins over w1c", v, 16'h0004);
    do_wr(4'd3, 16'h0004);
    aud_ev = 8'h80; step();
    do_wr(4'd6, 16'h0080);
    do_rd(4'd1, v); check("R9 audio summary", v, 16'h0002);
    do_wr(4'd5, 16'h0080);
    do_rd(4'd1, v); check("R8 audio w1c", v, 16'h0);
    // R10
    gp_ev = 8'h01; step();
    do_wr(4'd8, 16'h0001);
    do_rd(4'd3, v); check("R10 gpio feeds pm bit0", v, 16'h0001);
    do_wr(4'd4, 16'h0009);
    do_rd(4'd1, v); check("R10 top summary from gpio", v, 16'h0001);
    do_wr(4'd3, 16'h0001);
    do_rd(4'd3, v); check("R10 pm bit0 ignores w1c", v, 16'h0001);
    do_wr(4'd7, 16'h0001);
    do_rd(4'd1, v); check("R10 gpio clear reaches top", v, 16'h0);
    do_rd(4'd3, v); check("R10 pm bit0 cleared", v, 16'h0);
    do_rd(4'd12, v); check("R12 unmapped reads 0", v, 16'h0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 8;
      evt = 16'($urandom & $urandom & $urandom);
      pm_ev = 8'($urandom & $urandom & $urandom);
      aud_ev = 8'($urandom & $urandom & $urandom);
      gp_ev = 8'($urandom & $urandom & $urandom);
      susp = ($urandom % 16) == 0;
      addr = 4'($urandom % 10);
      wdata = 16'($urandom);
      if (op < 3) rd_en = 1;
      else if (op < 6) wr_en = 1;
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule